// File: doc/BRIEF.md
# PCI Slot Hotplug Event Controller

This block keeps the hot-insertion and hot-removal state for the slots on one PCI bus. It also raises a general-purpose event request that tells system software to look at that state. For each slot it holds three masks: device present, hotplug capable, and removal pending. The host side sees the masks through 32-bit registers with one bit per slot. The same host port reaches a 4-byte event block: two status bytes and two enable bytes.

On the platform side, a request carries a slot number, an insert/remove direction and a coldplug flag.

- A hot insert sets the slot's present bit and flags an event.
- A hot remove only posts a pending-removal bit and flags an event. The device stays present until software acknowledges.
- Software acknowledges by writing an eject mask. Only the lowest set slot in that mask is serviced. Its pending bit clears, and its present bit clears unless a non-removable device sits in that slot.
- A coldplug insert records presence silently.

The insertion register is not stored. It is computed from the present and capable masks. Synchronous reset leaves no removal pending. It loads the capable mask from the non-removable input and rebuilds the present mask from the occupied-slot input.

Top module: `slot_hp_evt`

## Requirements
- R1: While rst_n is low at a clock edge, the following are set: the pending mask to zero, the capable mask to the inverse of fixed_slots, the present mask to occupied, all four event bytes to zero, and gpe_irq low.
- R2: A read at HP_BASE+0 (0xAE00) returns present AND capable. A read at HP_BASE+12 (0xAE0C) returns the capable mask. A read at HP_BASE+4 (0xAE04) returns the pending mask. Bit n stands for slot n.
- R3: A request with plug_valid=1, plug_insert=1 and plug_cold=0 sets present[plug_slot] and bit 1 of status byte 0 (GPE_BASE+0, 0xAFE0).
- R4: A request with plug_valid=1 and plug_insert=0 sets pending[plug_slot] and bit 1 of status byte 0. The present mask is left unchanged.
- R5: A request with plug_valid=1, plug_insert=1 and plug_cold=1 sets present[plug_slot] only. The event status bytes are left unchanged.
- R6: A write at HP_BASE+8 (0xAE08) with a nonzero value services only the lowest set bit k. It clears pending[k], and it clears present[k] only when the live fixed_slots[k] is 0. A zero write changes nothing, and a read at that address returns zero.
- R7: Event bytes take io_wdata[7:0] and are read zero-extended. The status bytes at GPE_BASE+0/+1 are write-1-to-clear, and a same-cycle event set wins over the clear. The enable bytes at GPE_BASE+2/+3 are plain read/write.
- R8: gpe_irq is high exactly when bit 1 of status byte 0 and bit 1 of enable byte 0 are both set. It follows the edge of the write or event that changes them.
- R9: A hot or cold insert and an eject of the same slot in the same cycle leave that slot's present bit set.
- R10: io_rdata is zero when io_rd is low or when the address is none of the eight defined addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_wr | input | 1 | Host write strobe |
| io_rd | input | 1 | Host read strobe |
| io_addr | input | AW (16) | Host I/O address |
| io_wdata | input | 32 | Host write data |
| io_rdata | output | 32 | Host read data, combinational |
| plug_valid | input | 1 | Platform slot request valid |
| plug_insert | input | 1 | 1 = insert, 0 = remove |
| plug_cold | input | 1 | Coldplug insert, no event |
| plug_slot | input | SW (5) | Slot number of the request |
| fixed_slots | input | NSLOTS (32) | Slots holding non-removable devices |
| occupied | input | NSLOTS (32) | Slots occupied, loaded on reset |
| gpe_irq | output | 1 | General-purpose event request |

## Verification
The bench builds the block with its default parameters: 32 slots, the register window at 0xAE00 and the event block at 0xAFE0. With these values slot 31 is reachable at the top bit of every mask. Lowest-set-bit selection is exercised across the full 32-bit eject word, including words with many bits set. After reset the bench changes fixed_slots while the latched capable mask stays as it was. This makes the protected-present rule of an eject visible in the insertion register.

// File: rtl/slot_hp_evt.sv
module slot_hp_evt #(
  parameter int NSLOTS = 32,
  parameter int AW = 16,
  parameter logic [AW-1:0] HP_BASE = 'hAE00,
  parameter logic [AW-1:0] GPE_BASE = 'hAFE0,
  parameter int EVT_BIT = 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      io_wr,
  input  logic                      io_rd,
  input  logic [AW-1:0]             io_addr,
  input  logic [31:0]               io_wdata,
  output logic [31:0]               io_rdata,
  input  logic                      plug_valid,
  input  logic                      plug_insert,
  input  logic                      plug_cold,
  input  logic [$clog2(NSLOTS)-1:0] plug_slot,
  input  logic [NSLOTS-1:0]         fixed_slots,
  input  logic [NSLOTS-1:0]         occupied,
  output logic                      gpe_irq
);
  localparam logic [AW-1:0] A_UP = HP_BASE;
  localparam logic [AW-1:0] A_DN = HP_BASE + AW'(4);
  localparam logic [AW-1:0] A_EJ = HP_BASE + AW'(8);
  localparam logic [AW-1:0] A_RM = HP_BASE + AW'(12);
  localparam logic [AW-1:0] A_S0 = GPE_BASE;
  localparam logic [AW-1:0] A_S1 = GPE_BASE + AW'(1);
  localparam logic [AW-1:0] A_E0 = GPE_BASE + AW'(2);
  localparam logic [AW-1:0] A_E1 = GPE_BASE + AW'(3);
  localparam logic [7:0]    EVT_MASK = 8'(1 << EVT_BIT);

  logic [NSLOTS-1:0] present, pending, capable;
  logic [7:0] sts0, sts1, en0, en1;

  wire [NSLOTS-1:0] ej_val  = io_wdata[NSLOTS-1:0];
  wire              ej_wr   = io_wr && io_addr == A_EJ;
  wire [NSLOTS-1:0] ej_one  = ej_wr ? (ej_val & (~ej_val + NSLOTS'(1))) : '0;
  wire [NSLOTS-1:0] pl_one  = NSLOTS'(1) << plug_slot;
  wire [NSLOTS-1:0] ins_set = (plug_valid && plug_insert) ? pl_one : '0;
  wire [NSLOTS-1:0] rem_set = (plug_valid && !plug_insert) ? pl_one : '0;
  wire              hot_ev  = plug_valid && !(plug_insert && plug_cold);
  wire [7:0]        clr0    = (io_wr && io_addr == A_S0) ? io_wdata[7:0] : 8'h00;
  wire [7:0]        clr1    = (io_wr && io_addr == A_S1) ? io_wdata[7:0] : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      present <= occupied;
      pending <= '0;
      capable <= ~fixed_slots;
      sts0    <= 8'h00;
      sts1    <= 8'h00;
      en0     <= 8'h00;
      en1     <= 8'h00;
    end else begin
      present <= (present & ~(ej_one & ~fixed_slots)) | ins_set;
      pending <= (pending & ~ej_one) | rem_set;
      sts0    <= (sts0 & ~clr0) | (hot_ev ? EVT_MASK : 8'h00);
      sts1    <= sts1 & ~clr1;
      if (io_wr && io_addr == A_E0) en0 <= io_wdata[7:0];
      if (io_wr && io_addr == A_E1) en1 <= io_wdata[7:0];
    end
  end

  always_comb begin
    io_rdata = '0;
    if (io_rd) begin
      case (io_addr)
        A_UP:    io_rdata = 32'(present & capable);
        A_DN:    io_rdata = 32'(pending);
        A_RM:    io_rdata = 32'(capable);
        A_S0:    io_rdata = {24'h0, sts0};
        A_S1:    io_rdata = {24'h0, sts1};
        A_E0:    io_rdata = {24'h0, en0};
        A_E1:    io_rdata = {24'h0, en1};
        default: io_rdata = '0;
      endcase
    end
  end

  assign gpe_irq = sts0[EVT_BIT] & en0[EVT_BIT];
endmodule

// File: rtl/slot_hp_evt_chk.sv
module slot_hp_evt_chk #(
  parameter int NSLOTS = 32,
  parameter int AW = 16,
  parameter logic [AW-1:0] HP_BASE = 'hAE00,
  parameter int EVT_BIT = 1
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      io_wr,
  input logic                      io_rd,
  input logic [AW-1:0]             io_addr,
  input logic [31:0]               io_rdata,
  input logic                      plug_valid,
  input logic                      plug_insert,
  input logic                      plug_cold,
  input logic [$clog2(NSLOTS)-1:0] plug_slot,
  input logic                      gpe_irq,
  input logic [NSLOTS-1:0]         present,
  input logic [NSLOTS-1:0]         pending,
  input logic [7:0]                sts0
);
  localparam logic [AW-1:0] A_EJ = HP_BASE + AW'(8);
  wire ej = io_wr && io_addr == A_EJ;

  a_r3_hot_insert: assert property (@(posedge clk) disable iff (!rst_n)
    plug_valid && plug_insert && !plug_cold |=> present[$past(plug_slot)] && sts0[EVT_BIT]);

  a_r4_remove_posts: assert property (@(posedge clk) disable iff (!rst_n)
    plug_valid && !plug_insert |=> pending[$past(plug_slot)] && sts0[EVT_BIT]);

  a_r4_present_kept: assert property (@(posedge clk) disable iff (!rst_n)
    plug_valid && !plug_insert && !ej |=> present == $past(present));

  a_r5_cold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    plug_valid && plug_insert && plug_cold && !io_wr |=> $stable(sts0));

  a_r6_single_eject: assert property (@(posedge clk) disable iff (!rst_n)
    ej && !plug_valid |=> $countones($past(pending) & ~pending) <= 1
                         && $countones($past(present) & ~present) <= 1);

  a_r6_feature_zero: assert property (@(posedge clk) disable iff (!rst_n)
    io_rd && io_addr == A_EJ |-> io_rdata == 32'h0);

  a_r8_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gpe_irq) |-> $past(plug_valid || io_wr));

  a_r9_insert_wins: assert property (@(posedge clk) disable iff (!rst_n)
    plug_valid && plug_insert && ej |=> present[$past(plug_slot)]);
endmodule

bind slot_hp_evt slot_hp_evt_chk #(
  .NSLOTS(NSLOTS), .AW(AW), .HP_BASE(HP_BASE), .EVT_BIT(EVT_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
  .io_rdata(io_rdata), .plug_valid(plug_valid), .plug_insert(plug_insert),
  .plug_cold(plug_cold), .plug_slot(plug_slot), .gpe_irq(gpe_irq),
  .present(present), .pending(pending), .sts0(sts0)
);

// File: tb/slot_hp_evt_tb_top.sv
module slot_hp_evt_tb_top;
  localparam logic [31:0] FIX_A = 32'h8000_0005;
  localparam logic [31:0] OCC   = 32'h8000_10F3;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        io_wr = 0, io_rd = 0;
  logic [15:0] io_addr = 0;
  logic [31:0] io_wdata = 0;
  logic [31:0] io_rdata;
  logic        plug_valid = 0, plug_insert = 0, plug_cold = 0;
  logic [4:0]  plug_slot = 0;
  logic [31:0] fixed_slots = FIX_A;
  logic [31:0] occupied = OCC;
  logic        gpe_irq;

  int checks = 0, errors = 0;
  logic [31:0] m_pres, m_pend, m_cap;
  logic [7:0]  m_s0, m_s1, m_e0, m_e1;

  always #2 clk = ~clk;

  slot_hp_evt dut_i (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .plug_valid(plug_valid),
    .plug_insert(plug_insert), .plug_cold(plug_cold), .plug_slot(plug_slot),
    .fixed_slots(fixed_slots), .occupied(occupied), .gpe_irq(gpe_irq)
  );

  function automatic int lowest(input logic [31:0] v);
    for (int i = 0; i < 32; i++) if (v[i]) return i;
    return -1;
  endfunction

  function automatic logic [31:0] model_rd(input logic [15:0] a);
    case (a)
      16'hAE00: return m_pres & m_cap;
      16'hAE04: return m_pend;
      16'hAE0C: return m_cap;
      16'hAFE0: return {24'h0, m_s0};
      16'hAFE1: return {24'h0, m_s1};
      16'hAFE2: return {24'h0, m_e0};
      16'hAFE3: return {24'h0, m_e1};
      default:  return 32'h0;
    endcase
  endfunction

  task automatic model_reset();
    m_pres = occupied; m_pend = 0; m_cap = ~fixed_slots;
    m_s0 = 0; m_s1 = 0; m_e0 = 0; m_e1 = 0;
  endtask

  task automatic cyc(input bit pv, input bit pi, input bit pc, input logic [4:0] ps,
                     input bit w, input logic [15:0] a, input logic [31:0] d);
    int k;
    plug_valid = pv; plug_insert = pi; plug_cold = pc; plug_slot = ps;
    io_wr = w; io_addr = a; io_wdata = d;
    @(posedge clk); #1;
    plug_valid = 0; io_wr = 0;
    if (w) begin
      if (a == 16'hAE08 && d != 0) begin
        k = lowest(d);
        m_pend[k] = 1'b0;
        if (!fixed_slots[k]) m_pres[k] = 1'b0;
      end
      if (a == 16'hAFE0) m_s0 = m_s0 & ~d[7:0];
      if (a == 16'hAFE1) m_s1 = m_s1 & ~d[7:0];
      if (a == 16'hAFE2) m_e0 = d[7:0];
      if (a == 16'hAFE3) m_e1 = d[7:0];
    end
    if (pv) begin
      if (pi) m_pres[ps] = 1'b1; else m_pend[ps] = 1'b1;
      if (!(pi && pc)) m_s0[1] = 1'b1;
    end
  endtask

  task automatic chk_rd(input logic [15:0] a, input string tag);
    logic [31:0] exp;
    exp = model_rd(a);
    io_addr = a; io_rd = 1; #1;
    checks++;
    if (io_rdata !== exp) begin
      errors++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, io_rdata, exp);
    end
    io_rd = 0;
  endtask

  task automatic chk_irq(input string tag);
    logic exp;
    exp = m_s0[1] & m_e0[1];
    checks++;
    if (gpe_irq !== exp) begin
      errors++;
      $display("FAIL %s gpe_irq actual=%b expected=%b", tag, gpe_irq, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(posedge clk);
    #1; rst_n = 1;
    model_reset();
  endtask

  initial begin
    #(4 * 190000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] addrs [8];
    int r;
    logic [31:0] d;
    addrs = '{16'hAE00, 16'hAE04, 16'hAE08, 16'hAE0C, 16'hAFE0, 16'hAFE1, 16'hAFE2, 16'hAFE3};
    r = $urandom(32'h5EED_0042);

    do_reset();
    // R1, R2: reset state visible through all registers
    foreach (addrs[i]) chk_rd(addrs[i], "R1");
    chk_irq("R1");
    chk_rd(16'hAE00, "R2");
    chk_rd(16'hAE0C, "R2");

    // R3: hot insert slot 9
    cyc(1, 1, 0, 5'd9, 0, 0, 0);
    chk_rd(16'hAE00, "R3"); chk_rd(16'hAFE0, "R3"); chk_irq("R8");
    // R8: enable bit 1 raises the request
    cyc(0, 0, 0, 0, 1, 16'hAFE2, 32'h02);
    chk_irq("R8"); chk_rd(16'hAFE2, "R7");
    // R7: write-1-to-clear, zero write keeps
    cyc(0, 0, 0, 0, 1, 16'hAFE0, 32'h00);
    chk_rd(16'hAFE0, "R7");
    cyc(0, 0, 0, 0, 1, 16'hAFE0, 32'h02);
    chk_rd(16'hAFE0, "R7"); chk_irq("R8");
    // R7: clear and new event in the same cycle, event wins
    cyc(1, 1, 0, 5'd20, 1, 16'hAFE0, 32'hFF);
    chk_rd(16'hAFE0, "R7"); chk_irq("R8");
    cyc(0, 0, 0, 0, 1, 16'hAFE0, 32'hFF);
    cyc(0, 0, 0, 0, 1, 16'hAFE3, 32'hA5);
    chk_rd(16'hAFE3, "R7"); chk_rd(16'hAFE1, "R7");

    // R5: coldplug insert is silent
    cyc(1, 1, 1, 5'd10, 0, 0, 0);
    chk_rd(16'hAE00, "R5"); chk_rd(16'hAFE0, "R5"); chk_irq("R5");

    // R4: hot remove posts pending, present kept
    cyc(1, 0, 0, 5'd4, 0, 0, 0);
    cyc(1, 0, 0, 5'd5, 0, 0, 0);
    chk_rd(16'hAE04, "R4"); chk_rd(16'hAE00, "R4"); chk_rd(16'hAFE0, "R4");

    // R6: only the lowest set bit is serviced
    cyc(0, 0, 0, 0, 1, 16'hAE08, 32'h0000_0030);
    chk_rd(16'hAE04, "R6"); chk_rd(16'hAE00, "R6");
    cyc(0, 0, 0, 0, 1, 16'hAE08, 32'h0);
    chk_rd(16'hAE04, "R6"); chk_rd(16'hAE00, "R6");
    chk_rd(16'hAE08, "R6");
    // R6: slot 12 became non-removable after reset, present must survive
    fixed_slots = FIX_A | 32'h0000_1000;
    cyc(1, 0, 0, 5'd12, 0, 0, 0);
    cyc(0, 0, 0, 0, 1, 16'hAE08, 32'h0000_1000);
    chk_rd(16'hAE00, "R6"); chk_rd(16'hAE04, "R6");
    fixed_slots = FIX_A;
    // R6: top slot
    cyc(1, 1, 0, 5'd30, 0, 0, 0);
    cyc(1, 0, 0, 5'd30, 0, 0, 0);
    cyc(0, 0, 0, 0, 1, 16'hAE08, 32'hC000_0000);
    chk_rd(16'hAE00, "R6"); chk_rd(16'hAE04, "R6");

    // R9: insert and eject of the same slot together
    cyc(1, 0, 0, 5'd7, 0, 0, 0);
    cyc(1, 1, 0, 5'd7, 1, 16'hAE08, 32'h0000_0080);
    chk_rd(16'hAE00, "R9"); chk_rd(16'hAE04, "R9");

    // R10: unmapped addresses and idle read strobe
    chk_rd(16'hAE10, "R10"); chk_rd(16'hAFE4, "R10"); chk_rd(16'h1234, "R10");
    io_addr = 16'hAE0C; #1; checks++;
    if (io_rdata !== 0) begin
      errors++; $display("FAIL R10 idle read actual=%h expected=0", io_rdata);
    end

    // Random mix
    for (int it = 0; it < 600; it++) begin
      int op;
      op = $urandom_range(0, 5);
      case (op)
        0: cyc(1, 1, $urandom_range(0, 1), 5'($urandom), 0, 0, 0);
        1: cyc(1, 0, 0, 5'($urandom), 0, 0, 0);
        2: begin
             d = ($urandom_range(0, 1) != 0) ? (m_pend & $urandom) : $urandom;
             cyc($urandom_range(0, 1), 1, 0, 5'($urandom), 1, 16'hAE08, d);
           end
        3: cyc(0, 0, 0, 0, 1, 16'hAFE0 + 16'($urandom_range(0, 3)), $urandom);
        4: cyc($urandom_range(0, 1), $urandom_range(0, 1), 0, 5'($urandom),
               1, 16'hAFE0, $urandom);
        default: cyc(0, 0, 0, 0, 0, 0, 0);
      endcase
      chk_irq("R8");
      chk_rd(addrs[$urandom_range(0, 7)], "R2");
    end

    // R1: reset with removals pending
    cyc(1, 0, 0, 5'd3, 0, 0, 0);
    cyc(1, 0, 0, 5'd31, 0, 0, 0);
    do_reset();
    chk_rd(16'hAE04, "R1"); chk_rd(16'hAE00, "R1"); chk_rd(16'hAE0C, "R1");
    chk_rd(16'hAFE0, "R1"); chk_rd(16'hAFE2, "R1"); chk_irq("R1");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule